// File: doc/BRIEF.md
# Multi-dimensional work-group dispatcher

The block walks an index space of up to three dimensions and hands work groups to an array of compute units. Each compute unit is a SIMD group of lanes, and it runs one whole group at a time. The host side sets a global size and a local size for each dimension. A one- or two-dimensional space is described by setting the size of each unused dimension to 1. A start pulse then launches the run.

Groups are produced in a fixed order: x changes fastest, then y, then z. Each group goes to the free compute unit with the lowest index. For every group the block drives, per lane, a valid bit, a local ID and a global ID in each dimension, together with the group's ID. Lanes that fall outside the group are held idle. In a partial tail group, lanes that fall outside the index space are also held idle. Each compute unit has a ready input and a done input. The block flags completion once every group has been handed out and every unit has reported back.

The caller must keep every size at 1 or more, every local size at no more than the lane count, and the product of the three local sizes at no more than the lane count.

Top module: `ndr_dispatch`

## Requirements
- R1: After reset, `disp_vld_o`, `lane_vld_o`, `done_o`, `gid_o`, `lid_o` and `grp_o` are all zero.
- R2: `start_i` latches `gsize_i` and `lsize_i` only when no run is in progress. A `start_i` pulse during a run changes neither the sizes nor the sequence of groups of that run.
- R3: Groups are issued in order with x fastest, then y, then z. There are ceil(global/local) groups per dimension. `grp_o[c]` carries the group's index in each dimension (dimension 0 = x, 1 = y, 2 = z).
- R4: Lane l of a group takes local coordinates in x-fastest order: x = l mod Lx, y = (l / Lx) mod Ly, z = l / (Lx*Ly). Lanes with l >= Lx*Ly*Lz have `lane_vld_o` low.
- R5: For every valid lane, the global ID in each dimension equals the group index times the local size, plus the lane's local ID in that dimension.
- R6: A lane whose global ID reaches or exceeds the global size in any dimension has `lane_vld_o` low. Every lane with `lane_vld_o` low drives zero on all its `gid_o` and `lid_o` fields.
- R7: A group is issued to unit c only in a cycle where `cu_ready_i[c]` is high and unit c is not busy. A unit is busy from its issue until the clock edge at which `cu_done_i[c]` is high. At most one issue happens per cycle, shown as a one-cycle pulse on `disp_vld_o[c]` on the edge after the decision. The payload of unit c holds until that unit's next issue.
- R8: When several units are eligible, the unit with the lowest index is chosen.
- R9: `done_o` rises on the edge after the first edge at which all groups have been issued and no unit is busy. It stays high until the next accepted start, which clears it on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a run with the sizes presented on the same cycle |
| gsize_i | input | 3*SZ_W | Global size per dimension, x in the low field |
| lsize_i | input | 3*LS_W | Local size per dimension, x in the low field |
| cu_ready_i | input | NUM_CU | Unit can accept a group |
| cu_done_i | input | NUM_CU | One-cycle pulse: unit finished its group |
| disp_vld_o | output | NUM_CU | One-cycle pulse: new group on that unit's payload |
| lane_vld_o | output | NUM_CU*LANES | Per-lane active bit |
| gid_o | output | NUM_CU*LANES*3*SZ_W | Per-lane global ID per dimension |
| lid_o | output | NUM_CU*LANES*3*LS_W | Per-lane local ID per dimension |
| grp_o | output | NUM_CU*3*SZ_W | Group index per dimension |
| done_o | output | 1 | All groups issued and all units idle |

## Verification
The bench targets tail groups where the global size is not a multiple of the local size. A design that got these wrong would hand out IDs past the edge of the space or drop valid items. It also runs local shapes whose volume is below the lane count, where faulty lane mapping shows up as duplicate or skipped local IDs. It runs a one-dimensional space of size 255, where an adder sized too narrow wraps a global ID back below the limit. Random ready and done timing exercises issue to a busy unit, priority inversions and a completion flag that rises while a unit still works. A start pulse in the middle of a run catches a design that re-latches the sizes.

// File: rtl/ndr_pkg.sv
package ndr_pkg;
  localparam int unsigned NDIM = 3;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_e;
endpackage

// File: rtl/ndr_lane_map.sv
// Per-lane local coordinates, x-fastest, by an increment chain (no division).
module ndr_lane_map #(
  parameter int LANES = 4,
  parameter int LS_W  = 3
) (
  input  logic [2:0][LS_W-1:0]            lsize_i,
  output logic [LANES-1:0][2:0][LS_W-1:0] lid_o,
  output logic [LANES-1:0]                in_grp_o
);
  logic [LANES-1:0][2:0][LS_W-1:0] crd;

  always_comb begin
    crd = '0;
    for (int l = 1; l < LANES; l++) begin
      crd[l] = crd[l-1];
      if (crd[l-1][0] + LS_W'(1) == lsize_i[0]) begin
        crd[l][0] = '0;
        if (crd[l-1][1] + LS_W'(1) == lsize_i[1]) begin
          crd[l][1] = '0;
          crd[l][2] = crd[l-1][2] + LS_W'(1);
        end else begin
          crd[l][1] = crd[l-1][1] + LS_W'(1);
        end
      end else begin
        crd[l][0] = crd[l-1][0] + LS_W'(1);
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lid_o[l]    = crd[l];
    assign in_grp_o[l] = crd[l][2] < lsize_i[2];
  end
endmodule

// File: rtl/ndr_group_walk.sv
// Group position counter; bases advance by local size (no multiply).
module ndr_group_walk #(
  parameter int SZ_W = 8,
  parameter int LS_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  step_i,
  input  logic [2:0][SZ_W-1:0]  gsize_i,
  input  logic [2:0][LS_W-1:0]  lsize_i,
  output logic [2:0][SZ_W-1:0]  grp_o,
  output logic [2:0][SZ_W-1:0]  base_o,
  output logic                  last_o
);
  logic [2:0][SZ_W-1:0] grp_q, base_q, grp_d, base_d;
  logic [2:0]           wrap;

  for (genvar d = 0; d < 3; d++) begin : g_dim
    logic [SZ_W:0] nxt;
    assign nxt     = {1'b0, base_q[d]} + (SZ_W+1)'(lsize_i[d]);
    assign wrap[d] = nxt >= {1'b0, gsize_i[d]};
  end

  always_comb begin
    logic carry;
    grp_d  = grp_q;
    base_d = base_q;
    carry  = 1'b1;
    for (int d = 0; d < 3; d++) begin
      if (carry) begin
        if (wrap[d]) begin
          grp_d[d]  = '0;
          base_d[d] = '0;
        end else begin
          grp_d[d]  = grp_q[d] + SZ_W'(1);
          base_d[d] = base_q[d] + SZ_W'(lsize_i[d]);
        end
      end
      carry = carry & wrap[d];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      grp_q  <= '0;
      base_q <= '0;
    end else if (step_i) begin
      grp_q  <= grp_d;
      base_q <= base_d;
    end
  end

  assign grp_o  = grp_q;
  assign base_o = base_q;
  assign last_o = &wrap;
endmodule

// File: rtl/ndr_pick.sv
// Lowest-index-first one-hot grant.
module ndr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ndr_dispatch.sv
module ndr_dispatch
  import ndr_pkg::*;
#(
  parameter int NUM_CU = 4,
  parameter int LANES  = 4,
  parameter int SZ_W   = 8,
  parameter int LS_W   = $clog2(LANES) + 1
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       start_i,
  input  logic [2:0][SZ_W-1:0]                       gsize_i,
  input  logic [2:0][LS_W-1:0]                       lsize_i,
  input  logic [NUM_CU-1:0]                          cu_ready_i,
  input  logic [NUM_CU-1:0]                          cu_done_i,
  output logic [NUM_CU-1:0]                          disp_vld_o,
  output logic [NUM_CU-1:0][LANES-1:0]               lane_vld_o,
  output logic [NUM_CU-1:0][LANES-1:0][2:0][SZ_W-1:0] gid_o,
  output logic [NUM_CU-1:0][LANES-1:0][2:0][LS_W-1:0] lid_o,
  output logic [NUM_CU-1:0][2:0][SZ_W-1:0]           grp_o,
  output logic                                       done_o
);
  state_e                           st_q;
  logic [2:0][SZ_W-1:0]             gsz_q;
  logic [2:0][LS_W-1:0]             lsz_q;
  logic [NUM_CU-1:0]                busy_q, free, gnt;
  logic                             issue, accept, last;
  logic [2:0][SZ_W-1:0]             grp, base;
  logic [LANES-1:0][2:0][LS_W-1:0]  lid_w;
  logic [LANES-1:0]                 in_grp, pay_vld;
  logic [LANES-1:0][2:0][SZ_W-1:0]  pay_gid;
  logic [LANES-1:0][2:0][LS_W-1:0]  pay_lid;

  assign accept = start_i && (st_q == ST_IDLE);
  assign free   = ~busy_q & cu_ready_i;
  assign issue  = (st_q == ST_RUN) && (|free);

  ndr_pick #(.N(NUM_CU)) u_pick (.req_i(free), .gnt_o(gnt));

  ndr_group_walk #(.SZ_W(SZ_W), .LS_W(LS_W)) u_walk (
    .clk_i, .rst_ni,
    .load_i (accept),
    .step_i (issue),
    .gsize_i(gsz_q),
    .lsize_i(lsz_q),
    .grp_o  (grp),
    .base_o (base),
    .last_o (last)
  );

  ndr_lane_map #(.LANES(LANES), .LS_W(LS_W)) u_map (
    .lsize_i (lsz_q),
    .lid_o   (lid_w),
    .in_grp_o(in_grp)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2:0] in_rng;
    for (genvar d = 0; d < 3; d++) begin : g_dim
      logic [SZ_W:0] sum;
      assign sum           = {1'b0, base[d]} + (SZ_W+1)'(lid_w[l][d]);
      assign in_rng[d]     = sum < {1'b0, gsz_q[d]};
      assign pay_gid[l][d] = pay_vld[l] ? sum[SZ_W-1:0] : '0;
      assign pay_lid[l][d] = pay_vld[l] ? lid_w[l][d] : '0;
    end
    assign pay_vld[l] = in_grp[l] & (&in_rng);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      gsz_q  <= '0;
      lsz_q  <= '0;
      busy_q <= '0;
      done_o <= 1'b0;
    end else begin
      busy_q <= (busy_q & ~cu_done_i) | (issue ? gnt : '0);
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          gsz_q  <= gsize_i;
          lsz_q  <= lsize_i;
          done_o <= 1'b0;
          st_q   <= ST_RUN;
        end
        ST_RUN: if (issue && last) st_q <= ST_DRAIN;
        ST_DRAIN: if (busy_q == '0) begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Per-unit payload registers, loaded on that unit's issue only.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_vld_o <= '0;
      lane_vld_o <= '0;
      gid_o      <= '0;
      lid_o      <= '0;
      grp_o      <= '0;
    end else begin
      disp_vld_o <= issue ? gnt : '0;
      for (int c = 0; c < NUM_CU; c++) begin
        if (issue && gnt[c]) begin
          lane_vld_o[c] <= pay_vld;
          gid_o[c]      <= pay_gid;
          lid_o[c]      <= pay_lid;
          grp_o[c]      <= grp;
        end
      end
    end
  end
endmodule

// File: rtl/ndr_dispatch_chk.sv
module ndr_dispatch_chk #(
  parameter int NUM_CU = 4,
  parameter int LANES  = 4,
  parameter int SZ_W   = 8,
  parameter int LS_W   = 3
) (
  input logic                                       clk_i,
  input logic                                       rst_ni,
  input logic [NUM_CU-1:0]                          cu_ready_i,
  input logic [NUM_CU-1:0]                          cu_done_i,
  input logic [NUM_CU-1:0]                          disp_vld_o,
  input logic [NUM_CU-1:0][LANES-1:0]               lane_vld_o,
  input logic [NUM_CU-1:0][LANES-1:0][2:0][SZ_W-1:0] gid_o,
  input logic [NUM_CU-1:0][LANES-1:0][2:0][LS_W-1:0] lid_o,
  input logic                                       done_o,
  input logic [NUM_CU-1:0]                          busy_q
);
  // R7
  single_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_vld_o));

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_q == '0) && (disp_vld_o == '0));

  for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
    // R7
    ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_vld_o[c] |-> $past(cu_ready_i[c]));
    // R7
    busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q[c] && !cu_done_i[c] |=> !disp_vld_o[c]);
    // R4
    lane0_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_vld_o[c] |-> lane_vld_o[c][0]);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R6
      idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lane_vld_o[c][l] |-> (gid_o[c][l] == '0) && (lid_o[c][l] == '0));
    end
  end
endmodule

bind ndr_dispatch ndr_dispatch_chk #(
  .NUM_CU(NUM_CU), .LANES(LANES), .SZ_W(SZ_W), .LS_W(LS_W)
) u_chk (.*);

// File: tb/ndr_dispatch_tb.sv
`timescale 1ns/1ps
module ndr_dispatch_tb;
  localparam int NCU = 4, NL = 4, SZW = 8, LSW = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0][SZW-1:0] gsize = '0;
  logic [2:0][LSW-1:0] lsize = '0;
  logic [NCU-1:0] cu_ready = '0, cu_done = '0;
  logic [NCU-1:0] disp_vld;
  logic [NCU-1:0][NL-1:0] lane_vld;
  logic [NCU-1:0][NL-1:0][2:0][SZW-1:0] gid;
  logic [NCU-1:0][NL-1:0][2:0][LSW-1:0] lid;
  logic [NCU-1:0][2:0][SZW-1:0] grp;
  logic done;

  ndr_dispatch #(.NUM_CU(NCU), .LANES(NL), .SZ_W(SZW), .LS_W(LSW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gsize_i(gsize), .lsize_i(lsize),
    .cu_ready_i(cu_ready), .cu_done_i(cu_done), .disp_vld_o(disp_vld),
    .lane_vld_o(lane_vld), .gid_o(gid), .lid_o(lid), .grp_o(grp), .done_o(done));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit run_m = 0, done_m = 0, all_rdy = 0;
  logic [NCU-1:0] busy_m = '0;
  int timer [NCU];
  int js[3], jl[3], ng[3], e[3];
  int remaining = 0, issued = 0, total = 0;
  int last_grp [NCU][3];
  bit ever [NCU];

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_payload(int c);
    int lx, ly, lz, lc[3], g;
    bit v;
    for (int d = 0; d < 3; d++)
      chk(grp[c][d] == e[d], "R3", $sformatf("cu%0d grp dim%0d", c, d), grp[c][d], e[d]);
    for (int l = 0; l < NL; l++) begin
      lc[0] = l % jl[0];
      lc[1] = (l / jl[0]) % jl[1];
      lc[2] = l / (jl[0] * jl[1]);
      v = l < jl[0] * jl[1] * jl[2];
      if (!v) begin
        chk(lane_vld[c][l] == 1'b0, "R4", $sformatf("cu%0d lane%0d beyond volume", c, l),
            lane_vld[c][l], 0);
      end else begin
        for (int d = 0; d < 3; d++) if (e[d] * jl[d] + lc[d] >= js[d]) v = 0;
        chk(lane_vld[c][l] == v, "R6", $sformatf("cu%0d lane%0d valid", c, l), lane_vld[c][l], v);
      end
      for (int d = 0; d < 3; d++) begin
        g = v ? e[d] * jl[d] + lc[d] : 0;
        chk(gid[c][l][d] == g, v ? "R5" : "R6", $sformatf("cu%0d lane%0d gid dim%0d", c, l, d),
            gid[c][l][d], g);
        chk(lid[c][l][d] == (v ? lc[d] : 0), v ? "R4" : "R6",
            $sformatf("cu%0d lane%0d lid dim%0d", c, l, d), lid[c][l][d], v ? lc[d] : 0);
      end
    end
    for (int d = 0; d < 3; d++) last_grp[c][d] = e[d];
    ever[c] = 1;
  endtask

  task automatic tick();
    logic [NCU-1:0] free, exp_vld;
    bit iss, exp_done, take;
    int pc;
    free = ~busy_m & cu_ready;
    iss = run_m && remaining > 0 && free != '0;
    exp_vld = '0;
    pc = -1;
    if (iss) begin
      for (int c = NCU - 1; c >= 0; c--) if (free[c]) pc = c;
      exp_vld[pc] = 1'b1;
    end
    exp_done = done_m || (run_m && remaining == 0 && busy_m == '0);
    take = start && !run_m;
    @(posedge clk);
    @(negedge clk);
    busy_m = (busy_m & ~cu_done) | exp_vld;
    if (exp_done && !done_m) run_m = 0;
    done_m = exp_done;
    if (take) begin
      run_m = 1; done_m = 0;
      for (int d = 0; d < 3; d++) begin
        js[d] = gsize[d]; jl[d] = lsize[d];
        ng[d] = (js[d] + jl[d] - 1) / jl[d]; e[d] = 0;
      end
      total = ng[0] * ng[1] * ng[2];
      remaining = total; issued = 0;
    end
    chk(disp_vld == exp_vld, "R8", "issue vector (R7 gating)", disp_vld, exp_vld);
    chk(done == done_m, "R9", "done flag", done, done_m);
    if (iss) begin
      check_payload(pc);
      timer[pc] = 1 + $urandom % 4;
      remaining--; issued++;
      e[0]++;
      if (e[0] == ng[0]) begin
        e[0] = 0; e[1]++;
        if (e[1] == ng[1]) begin e[1] = 0; e[2]++; end
      end
    end
    start = 1'b0;
    for (int c = 0; c < NCU; c++) begin
      cu_done[c] = 1'b0;
      if (busy_m[c]) begin
        timer[c]--;
        if (timer[c] <= 0) cu_done[c] = 1'b1;
      end
      cu_ready[c] = all_rdy ? 1'b1 : (($urandom % 4) != 0);
    end
  endtask

  task automatic run_job(int gx, int gy, int gz, int lx, int ly, int lz, bit restart);
    int n;
    gsize[0] = SZW'(gx); gsize[1] = SZW'(gy); gsize[2] = SZW'(gz);
    lsize[0] = LSW'(lx); lsize[1] = LSW'(ly); lsize[2] = LSW'(lz);
    start = 1'b1;
    n = 0;
    do begin
      tick();
      n++;
      if (restart && n == 3) begin
        gsize = {SZW'(2), SZW'(2), SZW'(2)};
        lsize = {LSW'(1), LSW'(1), LSW'(1)};
        start = 1'b1;
      end
    end while (!done_m && n < 20000);
    tick(); tick();
    chk(issued == total, "R2", "groups issued in run", issued, total);
    for (int c = 0; c < NCU; c++)
      if (ever[c])
        for (int d = 0; d < 3; d++)
          chk(grp[c][d] == last_grp[c][d], "R7", $sformatf("cu%0d payload hold", c),
              grp[c][d], last_grp[c][d]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: got running 1 exp done 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a, b, c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(disp_vld == '0, "R1", "disp_vld after reset", disp_vld, 0);
    chk(lane_vld == '0, "R1", "lane_vld after reset", lane_vld, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(gid == '0 && lid == '0 && grp == '0, "R1", "id buses after reset", 1, 0);
    all_rdy = 1;
    cu_ready = '1;
    run_job(10, 1, 1, 4, 1, 1, 0);
    run_job(5, 3, 1, 2, 2, 1, 0);
    all_rdy = 0;
    run_job(3, 2, 2, 2, 1, 2, 0);
    run_job(7, 2, 1, 3, 1, 1, 0);
    run_job(1, 1, 1, 1, 1, 1, 0);
    run_job(255, 1, 1, 4, 1, 1, 0);
    run_job(6, 5, 3, 1, 2, 2, 1);
    run_job(4, 4, 4, 4, 1, 1, 1);
    for (int k = 0; k < 8; k++) begin
      a = 1 + $urandom % 4;
      b = 1 + $urandom % (4 / a);
      c = 1 + $urandom % (4 / (a * b));
      run_job(1 + $urandom % 10, 1 + $urandom % 10, 1 + $urandom % 6, a, b, c, k[0]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule